// File: doc/BRIEF.md
# Reference-Injection Select and Phase Controller

This block is the digital control for a multiplying delay-locked loop. It runs on a fast sampling clock and watches three signals: the reference clock, the recirculating oscillator output and the end-of-count pulse from the oscillator divider. When the end-of-count pulse arrives, the block raises a select output on the next falling oscillator edge. Select tells the delay line's input multiplexer to take a fresh reference edge in place of its own feedback. While select is high, the block measures how long the reference is high before the oscillator, and how long the oscillator is high before the reference. Select falls once both are high. At that moment the oscillator restarts, aligned to the reference edge.

At the end of every select window the block moves an unsigned delay code by one step at most. A larger code means a longer delay. Reset puts the code at zero, the shortest delay, so the oscillator starts at its fastest and the loop always settles from above. A lock flag reports a run of comparisons that stay close to one code value. A reference watchdog flags a missing reference edge without disturbing the code. After several missing edges in a row, it pulses a restart that returns the controller to its reset state.

The select sequencer has three states. RUN is the free-running state. The transition *arm* (a rising end-of-count pulse) moves it to ARMED. The transition *inject* (a sampled falling oscillator edge) moves it to INJECT, where select is high. The transition *release* (reference and oscillator both sampled high) returns it to RUN. A restart forces it to RUN from any state.

Top module: `mdll_inject_ctrl`

## Requirements
- R1: After reset, select, up, down, lock and missing-reference outputs are 0 and the delay code is 0 (shortest delay).
- R2: Select rises only after a rising end-of-count pulse has been seen and the oscillator has then fallen. An oscillator falling edge with no preceding end-of-count pulse leaves select at 0.
- R3: Once high, select stays high while either the reference or the oscillator is sampled low. It falls only after both are sampled high.
- R4: Up is 1 exactly while select is high, the reference is high and the oscillator is low. Down is 1 exactly while select is high, the oscillator is high and the reference is low. Both are 0 while select is low.
- R5: When select falls, the code decreases by one if up was high for more samples than down. It increases by one if down was high for more samples. It is unchanged if the counts are equal. A larger code means a longer delay.
- R6: The code saturates at 0 and at 2^CODE_W-1 and never wraps.
- R7: The lock output is 1 once LOCK_CMP consecutive window ends leave the code within one step of a held reference value. A window end further away than one step moves the reference value and clears lock.
- R8: The missing-reference output is set when REF_TIMEOUT samples pass with no reference rising edge. It clears on the next reference rising edge. A single miss leaves the code unchanged.
- R9: After MISS_LIMIT consecutive timeouts, a one-sample restart pulse returns the code to 0, clears lock and puts the sequencer in RUN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_clk_i | input | 1 | Reference clock |
| osc_clk_i | input | 1 | Oscillator output |
| last_i | input | 1 | End-of-count pulse from the divider |
| sel_o | output | 1 | Select reference edge into the delay line |
| up_o | output | 1 | Oscillator lags the reference (shorten delay) |
| dn_o | output | 1 | Oscillator leads the reference (lengthen delay) |
| dly_code_o | output | CODE_W | Delay control code, 0 = shortest |
| locked_o | output | 1 | Loop settled |
| ref_missing_o | output | 1 | Reference edge overdue |
| restart_o | output | 1 | Restart pulse after repeated misses |

## Verification
Select windows are driven with three edge orders: reference first, oscillator first, and both in the same sample. These separate the decrement, increment and hold paths of the code update, and the up and down pulses are sampled in mid-window to confirm which one fires. Long runs of one-sided windows push the code against both saturation limits. A run of same-sample windows separates the lock threshold from the comparison before it. Stray oscillator falls and reference rises outside a window check that the sequencer ignores them. A stretch with the reference held low separates a single miss, which must leave the code alone, from the repeated misses that must restart the controller.

// File: rtl/mdll_ctrl_pkg.sv
package mdll_ctrl_pkg;
    typedef enum logic [1:0] {
        SEL_RUN    = 2'd0,
        SEL_ARMED  = 2'd1,
        SEL_INJECT = 2'd2
    } sel_state_e;

    localparam int IN_REF  = 0;
    localparam int IN_OSC  = 1;
    localparam int IN_LAST = 2;
    localparam int IN_NUM  = 3;
endpackage

// File: rtl/mdll_in_sample.sv
module mdll_in_sample #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] raw_i,
    output logic [N-1:0] cur_o,
    output logic [N-1:0] prv_o
);
    for (genvar i = 0; i < N; i++) begin : g_tap
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cur_o[i] <= 1'b0;
                prv_o[i] <= 1'b0;
            end else begin
                cur_o[i] <= raw_i[i];
                prv_o[i] <= cur_o[i];
            end
        end
    end
endmodule

// File: rtl/mdll_sel_fsm.sv
module mdll_sel_fsm
    import mdll_ctrl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic last_rise_i,
    input  logic osc_fall_i,
    input  logic ref_lvl_i,
    input  logic osc_lvl_i,
    output logic sel_o,
    output logic win_end_o
);
    sel_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) state_q <= SEL_RUN;
        else                 state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEL_RUN:    if (last_rise_i)             state_d = SEL_ARMED;
            SEL_ARMED:  if (osc_fall_i)              state_d = SEL_INJECT;
            SEL_INJECT: if (ref_lvl_i && osc_lvl_i)  state_d = SEL_RUN;
            default:                                 state_d = SEL_RUN;
        endcase
    end

    always_comb begin
        sel_o     = (state_q == SEL_INJECT);
        win_end_o = sel_o && ref_lvl_i && osc_lvl_i;
    end

    assert_sel_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sel_o) |-> $past(osc_fall_i));

    assert_sel_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(sel_o) && !$past(clr_i)) |-> $past(ref_lvl_i && osc_lvl_i));
endmodule

// File: rtl/mdll_code_loop.sv
module mdll_code_loop #(
    parameter int CODE_W   = 8,
    parameter int CNT_W    = 12,
    parameter int LOCK_CMP = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              sel_i,
    input  logic              ref_lvl_i,
    input  logic              osc_lvl_i,
    input  logic              win_end_i,
    output logic              up_o,
    output logic              dn_o,
    output logic [CODE_W-1:0] code_o,
    output logic              locked_o
);
    localparam int LOCK_W = $clog2(LOCK_CMP + 1);
    localparam logic [CODE_W-1:0] CODE_MAX = '1;

    logic [CNT_W-1:0]  up_cnt, dn_cnt;
    logic [CODE_W-1:0] code_q, code_d, ref_code;
    logic [LOCK_W-1:0] lock_cnt;
    logic              near;

    always_comb begin
        up_o = sel_i && ref_lvl_i && !osc_lvl_i;
        dn_o = sel_i && osc_lvl_i && !ref_lvl_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr_i || !sel_i) begin
            up_cnt <= '0;
            dn_cnt <= '0;
        end else begin
            if (up_o && up_cnt != '1) up_cnt <= up_cnt + 1'b1;
            if (dn_o && dn_cnt != '1) dn_cnt <= dn_cnt + 1'b1;
        end
    end

    always_comb begin
        code_d = code_q;
        if (win_end_i) begin
            if (up_cnt > dn_cnt && code_q != '0)            code_d = code_q - 1'b1;
            else if (dn_cnt > up_cnt && code_q != CODE_MAX) code_d = code_q + 1'b1;
        end
        near = ({1'b0, code_d} == {1'b0, ref_code})
            || ({1'b0, code_d} == {1'b0, ref_code} + 1'b1)
            || ({1'b0, code_d} + 1'b1 == {1'b0, ref_code});
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            code_q   <= '0;
            ref_code <= '0;
            lock_cnt <= '0;
        end else begin
            code_q <= code_d;
            if (win_end_i) begin
                if (!near) begin
                    ref_code <= code_d;
                    lock_cnt <= '0;
                end else if (lock_cnt != LOCK_W'(LOCK_CMP)) begin
                    lock_cnt <= lock_cnt + 1'b1;
                end
            end
        end
    end

    assign code_o   = code_q;
    assign locked_o = (lock_cnt == LOCK_W'(LOCK_CMP));

    assert_code_step_R5: assert property (@(posedge clk) disable iff (!rst_n || clr_i)
        ((code_q != $past(code_q)) && !$past(clr_i)) |->
        (({1'b0, code_q} == {1'b0, $past(code_q)} + 1'b1) ||
         ({1'b0, code_q} + 1'b1 == {1'b0, $past(code_q)})));

    assert_code_change_at_end_R6: assert property (@(posedge clk) disable iff (!rst_n || clr_i)
        ((code_q != $past(code_q)) && !$past(clr_i)) |-> $past(win_end_i));

    assert_lock_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked_o) |-> $past(win_end_i));
endmodule

// File: rtl/mdll_ref_watch.sv
module mdll_ref_watch #(
    parameter int REF_TIMEOUT = 1024,
    parameter int MISS_LIMIT  = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_rise_i,
    output logic missing_o,
    output logic restart_o
);
    localparam int TIMER_W = $clog2(REF_TIMEOUT + 1);
    localparam int MISS_W  = $clog2(MISS_LIMIT + 1);

    logic [TIMER_W-1:0] timer;
    logic [MISS_W-1:0]  miss_cnt;
    logic               expire;

    assign expire = (timer == TIMER_W'(REF_TIMEOUT - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            timer     <= '0;
            miss_cnt  <= '0;
            restart_o <= 1'b0;
        end else begin
            restart_o <= 1'b0;
            if (ref_rise_i) begin
                timer    <= '0;
                miss_cnt <= '0;
            end else if (expire) begin
                timer <= '0;
                if (miss_cnt == MISS_W'(MISS_LIMIT - 1)) begin
                    miss_cnt  <= '0;
                    restart_o <= 1'b1;
                end else begin
                    miss_cnt <= miss_cnt + 1'b1;
                end
            end else begin
                timer <= timer + 1'b1;
            end
        end
    end

    assign missing_o = (miss_cnt != '0);

    assert_missing_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(missing_o) |-> !$past(ref_rise_i));

    assert_restart_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        restart_o |=> !restart_o);
endmodule

// File: rtl/mdll_inject_ctrl.sv
module mdll_inject_ctrl
    import mdll_ctrl_pkg::*;
#(
    parameter int CODE_W      = 8,
    parameter int CNT_W       = 12,
    parameter int LOCK_CMP    = 16,
    parameter int REF_TIMEOUT = 1024,
    parameter int MISS_LIMIT  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_clk_i,
    input  logic              osc_clk_i,
    input  logic              last_i,
    output logic              sel_o,
    output logic              up_o,
    output logic              dn_o,
    output logic [CODE_W-1:0] dly_code_o,
    output logic              locked_o,
    output logic              ref_missing_o,
    output logic              restart_o
);
    logic [IN_NUM-1:0] raw, cur, prv;
    logic ref_rise, osc_fall, last_rise, win_end, restart;

    always_comb begin
        raw          = '0;
        raw[IN_REF]  = ref_clk_i;
        raw[IN_OSC]  = osc_clk_i;
        raw[IN_LAST] = last_i;
        ref_rise     = cur[IN_REF]  && !prv[IN_REF];
        osc_fall     = !cur[IN_OSC] && prv[IN_OSC];
        last_rise    = cur[IN_LAST] && !prv[IN_LAST];
    end

    mdll_in_sample #(.N(IN_NUM)) u_sample (
        .clk(clk), .rst_n(rst_n), .raw_i(raw), .cur_o(cur), .prv_o(prv)
    );

    mdll_sel_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .clr_i(restart),
        .last_rise_i(last_rise), .osc_fall_i(osc_fall),
        .ref_lvl_i(cur[IN_REF]), .osc_lvl_i(cur[IN_OSC]),
        .sel_o(sel_o), .win_end_o(win_end)
    );

    mdll_code_loop #(.CODE_W(CODE_W), .CNT_W(CNT_W), .LOCK_CMP(LOCK_CMP)) u_loop (
        .clk(clk), .rst_n(rst_n), .clr_i(restart), .sel_i(sel_o),
        .ref_lvl_i(cur[IN_REF]), .osc_lvl_i(cur[IN_OSC]), .win_end_i(win_end),
        .up_o(up_o), .dn_o(dn_o), .code_o(dly_code_o), .locked_o(locked_o)
    );

    mdll_ref_watch #(.REF_TIMEOUT(REF_TIMEOUT), .MISS_LIMIT(MISS_LIMIT)) u_watch (
        .clk(clk), .rst_n(rst_n), .ref_rise_i(ref_rise),
        .missing_o(ref_missing_o), .restart_o(restart)
    );

    assign restart_o = restart;

    assert_updn_in_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (up_o || dn_o) |-> (sel_o && (cur[IN_REF] != cur[IN_OSC])));
endmodule

// File: tb/tb_mdll_inject_ctrl.sv
module tb_mdll_inject_ctrl;
    localparam int CODE_W = 8;
    localparam int TMO    = 64;
    localparam int MAXC   = (1 << CODE_W) - 1;

    logic clk = 1'b0, rst_n = 1'b0;
    logic ref_clk = 1'b0, osc_clk = 1'b1, last = 1'b0;
    logic sel, up, dn, locked, missing, restart;
    logic [CODE_W-1:0] code;

    int n_chk = 0, n_bad = 0, n_restart = 0, exp_code = 0, cyc = 0;
    int exp_q[$];
    logic prev_sel = 1'b0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    mdll_inject_ctrl #(.CODE_W(CODE_W), .CNT_W(12), .LOCK_CMP(16),
                       .REF_TIMEOUT(TMO), .MISS_LIMIT(3)) dut (
        .clk(clk), .rst_n(rst_n), .ref_clk_i(ref_clk), .osc_clk_i(osc_clk),
        .last_i(last), .sel_o(sel), .up_o(up), .dn_o(dn), .dly_code_o(code),
        .locked_o(locked), .ref_missing_o(missing), .restart_o(restart)
    );

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cyc);
        end
    endtask

    // monitor: pops the expected code at every window end
    always @(negedge clk) begin
        cyc++;
        if (restart) n_restart++;
        if (prev_sel && !sel) begin
            if (exp_q.size() == 0) check("R5 unexpected window end", 1, 0);
            else check("R5/R6 code after window", int'(code), exp_q.pop_front());
        end
        prev_sel <= sel;
    end

    // mode 0: same sample, 1: reference first (up), 2: oscillator first (down)
    task automatic inject(int mode);
        @(negedge clk) last = 1'b1;
        @(negedge clk) last = 1'b0;
        repeat (2) @(negedge clk);
        osc_clk = 1'b0;
        repeat (5) @(negedge clk);
        check("R2 select after arm and fall", int'(sel), 1);
        if (mode == 1) begin
            exp_code = (exp_code > 0) ? exp_code - 1 : 0;
            ref_clk = 1'b1;
            repeat (3) @(negedge clk);
            check("R4 up while oscillator lags", int'(up), 1);
            check("R4 no down while oscillator lags", int'(dn), 0);
            check("R3 select held, oscillator low", int'(sel), 1);
            exp_q.push_back(exp_code);
            osc_clk = 1'b1;
        end else if (mode == 2) begin
            exp_code = (exp_code < MAXC) ? exp_code + 1 : MAXC;
            osc_clk = 1'b1;
            repeat (3) @(negedge clk);
            check("R4 down while oscillator leads", int'(dn), 1);
            check("R4 no up while oscillator leads", int'(up), 0);
            check("R3 select held, reference low", int'(sel), 1);
            exp_q.push_back(exp_code);
            ref_clk = 1'b1;
        end else begin
            exp_q.push_back(exp_code);
            ref_clk = 1'b1;
            osc_clk = 1'b1;
        end
        repeat (4) @(negedge clk);
        check("R3 select released with both high", int'(sel), 0);
        check("R4 up/down idle after window", int'(up || dn), 0);
        ref_clk = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset select", int'(sel), 0);
        check("R1 reset code", int'(code), 0);
        check("R1 reset lock", int'(locked), 0);
        check("R1 reset missing", int'(missing), 0);
        check("R1 reset up/down", int'(up || dn), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2: oscillator fall without end-of-count is ignored
        osc_clk = 1'b0;
        repeat (6) @(negedge clk);
        check("R2 no select without arm", int'(sel), 0);
        osc_clk = 1'b1;
        repeat (2) @(negedge clk);
        // R4: reference high outside a window gives no up
        ref_clk = 1'b1;
        repeat (3) @(negedge clk);
        check("R4 no up outside window", int'(up), 0);
        ref_clk = 1'b0;
        repeat (2) @(negedge clk);

        // R7: lock threshold
        for (int i = 0; i < 15; i++) inject(0);
        check("R7 not locked after 15", int'(locked), 0);
        inject(0);
        check("R7 locked after 16", int'(locked), 1);

        // R6: saturation at zero
        inject(1);
        check("R6 floor holds", int'(code), 0);

        for (int i = 0; i < 5; i++) inject(2);
        check("R5 code after five increments", int'(code), 5);
        check("R7 lock cleared by drift", int'(locked), 0);
        inject(1);
        check("R5 code after decrement", int'(code), 4);

        // R6: saturation at the top
        for (int i = 0; i < MAXC; i++) inject(2);
        check("R6 ceiling holds", int'(code), MAXC);
        inject(1);
        check("R6 step down from ceiling", int'(code), MAXC - 1);

        // R8 / R9: missing reference
        check("R9 no restart yet", n_restart, 0);
        repeat (80) @(negedge clk);
        check("R8 missing flag after one timeout", int'(missing), 1);
        check("R8 single miss leaves code", int'(code), MAXC - 1);
        repeat (150) @(negedge clk);
        check("R9 one restart pulse", n_restart, 1);
        check("R9 code back to zero", int'(code), 0);
        check("R9 lock cleared", int'(locked), 0);
        check("R9 sequencer idle", int'(sel), 0);
        exp_code = 0;
        inject(2);
        check("R8 missing cleared on reference edge", int'(missing), 0);
        check("R9 loop runs after restart", int'(code), 1);

        check("R5 all windows observed", exp_q.size(), 0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(negedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule